// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block compares the rising edges of a reference square wave with those of a feedback square wave coming back from an oscillator. Both inputs are asynchronous to the fast system clock. Each one passes through a synchroniser chain and then an edge detector. A small state memory then decides whether the loop must speed the oscillator up, slow it down, or leave it alone. Falling edges play no part, so the duty cycle of either input has no effect on the result.

The correction output models a three-state charge-pump drive. It consists of an enable, which is high while a correction is driven, and a level, which is 1 for pump-up and 0 for pump-down. Decoded up and down pulses are also provided. A status output is high whenever nothing is being driven. A registered lock flag is built on top of that status. It sets after a programmable number of clean reference periods and clears when any single correction lasts longer than a programmable number of clock cycles.

Top module: `pfd_top`

## Requirements
- R1: A synchronous active-high reset clears the synchronisers, the state memory and the lock logic. In the first cycle after reset the enable, both pump outputs and the lock flag are 0 and the status output is 1.
- R2: If a reference rising edge is seen while the block is idle and no feedback rising edge is seen in the same cycle, the block drives pump-up until the next feedback rising edge and then returns to idle.
- R3: If a feedback rising edge is seen while the block is idle and no reference rising edge is seen in the same cycle, the block drives pump-down until the next reference rising edge and then returns to idle.
- R4: Output encoding:
  - `drive_en`=1 means driving. `drive_lvl`=1 means pump-up and `drive_lvl`=0 means pump-down.
  - `pump_up` = `drive_en` and `drive_lvl`.
  - `pump_dn` = `drive_en` and not `drive_lvl`.
  - `pump_up` and `pump_dn` are never high together.
- R5: `status_idle` is 1 exactly when `drive_en` is 0.
- R6: Timing and duty cycle:
  - An input change is first visible at the outputs in the third clock after the edge that first samples it.
  - A correction therefore lasts exactly as many clock cycles as the spacing between the two rising edges.
  - The length of the high time of either input has no effect.
- R7: Rising edges on both inputs detected in the same cycle return the block to idle, or keep it there.
- R8: While the reference has no rising edges, every feedback rising edge keeps the block in pump-down, and pump-up never occurs.
- R9: If the feedback runs at a lower frequency than the reference, pump-up is driven for more than half the time and pump-down never is. If the feedback runs at a higher frequency, the reverse holds.
- R10: The lock flag sets once LOCK_PERIODS consecutive reference periods have ended with the status high throughout. It is clear before that.
- R11: A correction longer than MAX_CORR cycles clears the lock flag. A correction of exactly MAX_CORR cycles leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fbk_in | input | 1 | Feedback square wave from the oscillator, asynchronous |
| drive_en | output | 1 | High while a correction is driven |
| drive_lvl | output | 1 | Correction level: 1 pump-up, 0 pump-down |
| pump_up | output | 1 | Pump-up pulse |
| pump_dn | output | 1 | Pump-down pulse |
| status_idle | output | 1 | High while the output is undriven |
| locked | output | 1 | Registered lock indication |

## Verification
A wrong state memory appears at the pump outputs three clocks after the offending input change, for example as a correction that is one cycle too long or a pump that never releases. The bench therefore counts pump cycles for every edge spacing and high time of a small sweep, and compares each count with the spacing itself. Errors in the lock logic appear on the flag within two clocks of the reference edge or the correction cycle that should have moved it, so the bench probes the flag on either side of each threshold.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'b00,
        PFD_UP   = 2'b01,
        PFD_DN   = 2'b10
    } pfd_state_e;

    typedef struct packed {
        logic ref_rise;
        logic fbk_rise;
    } edge_pair_t;

    typedef struct packed {
        logic en;
        logic lvl;
    } drive_t;

    function automatic pfd_state_e pfd_next(pfd_state_e cur, edge_pair_t e);
        pfd_state_e nxt;
        nxt = cur;
        if (e.ref_rise && e.fbk_rise) begin
            nxt = PFD_IDLE;
        end else begin
            case (cur)
                PFD_IDLE: begin
                    if (e.ref_rise)      nxt = PFD_UP;
                    else if (e.fbk_rise) nxt = PFD_DN;
                end
                PFD_UP:   if (e.fbk_rise) nxt = PFD_IDLE;
                PFD_DN:   if (e.ref_rise) nxt = PFD_IDLE;
                default:  nxt = PFD_IDLE;
            endcase
        end
        return nxt;
    endfunction

    function automatic drive_t pfd_encode(pfd_state_e s);
        drive_t d;
        d.en  = (s != PFD_IDLE);
        d.lvl = (s == PFD_UP);
        return d;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[LAST-1:0], din};
    end

    assign rise = shreg[LAST-1] & ~shreg[LAST];
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_pair_t edges,
    output pfd_state_e state,
    output drive_t     drv
);
    always_ff @(posedge clk) begin
        if (rst) state <= PFD_IDLE;
        else     state <= pfd_next(state, edges);
    end

    assign drv = pfd_encode(state);
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
    parameter int LOCK_PERIODS = 16,
    parameter int MAX_CORR     = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic idle,
    output logic locked
);
    localparam int PW = $clog2(LOCK_PERIODS + 1);
    localparam int CW = $clog2(MAX_CORR + 2);
    localparam logic [PW-1:0] RUN_TGT  = PW'(LOCK_PERIODS);
    localparam logic [CW-1:0] CORR_TGT = CW'(MAX_CORR);

    logic [PW-1:0] run_cnt;
    logic [CW-1:0] corr_len;
    logic          dirty;
    logic          long_corr;
    logic          period_clean;

    assign long_corr    = !idle && (corr_len >= CORR_TGT);
    assign period_clean = !dirty && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_len <= '0;
        end else if (idle) begin
            corr_len <= '0;
        end else if (corr_len < CORR_TGT) begin
            corr_len <= corr_len + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty   <= 1'b0;
            run_cnt <= '0;
        end else if (long_corr) begin
            dirty   <= 1'b1;
            run_cnt <= '0;
        end else if (ref_rise) begin
            dirty <= 1'b0;
            if (!period_clean)       run_cnt <= '0;
            else if (run_cnt < RUN_TGT) run_cnt <= run_cnt + 1'b1;
        end else if (!idle) begin
            dirty <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    locked <= 1'b0;
        else if (long_corr)         locked <= 1'b0;
        else if (run_cnt == RUN_TGT) locked <= 1'b1;
    end
endmodule

// File: rtl/pfd_top.sv
module pfd_top
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int LOCK_PERIODS = 16,
    parameter int MAX_CORR     = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fbk_in,
    output logic drive_en,
    output logic drive_lvl,
    output logic pump_up,
    output logic pump_dn,
    output logic status_idle,
    output logic locked
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_in;
    logic [NCH-1:0] rise_v;
    logic           ref_rise;
    logic           fbk_rise;
    edge_pair_t     edges;
    pfd_state_e     state;
    drive_t         drv;

    assign raw_in = {fbk_in, ref_in};

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_sync
            pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (raw_in[g]),
                .rise (rise_v[g])
            );
        end
    endgenerate

    assign ref_rise       = rise_v[0];
    assign fbk_rise       = rise_v[1];
    assign edges.ref_rise = ref_rise;
    assign edges.fbk_rise = fbk_rise;

    pfd_core u_core (
        .clk   (clk),
        .rst   (rst),
        .edges (edges),
        .state (state),
        .drv   (drv)
    );

    pfd_lock #(.LOCK_PERIODS(LOCK_PERIODS), .MAX_CORR(MAX_CORR)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (ref_rise),
        .idle     (state == PFD_IDLE),
        .locked   (locked)
    );

    assign drive_en    = drv.en;
    assign drive_lvl   = drv.lvl;
    assign pump_up     = drv.en && drv.lvl;
    assign pump_dn     = drv.en && !drv.lvl;
    assign status_idle = !drv.en;
endmodule

// File: rtl/pfd_chk.sv
module pfd_chk (
    input logic clk,
    input logic rst,
    input logic ref_rise,
    input logic fbk_rise,
    input logic pump_up,
    input logic pump_dn,
    input logic status_idle,
    input logic locked
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (status_idle && !locked && !pump_up && !pump_dn));

    // R2
    up_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pump_up && fbk_rise) |=> status_idle);

    // R3
    dn_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pump_dn && ref_rise) |=> status_idle);

    // R2
    up_start_chk: assert property (@(posedge clk) disable iff (rst)
        (status_idle && ref_rise && !fbk_rise) |=> pump_up);

    // R4
    pump_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pump_up && pump_dn));

    // R7
    both_edges_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && fbk_rise) |=> status_idle);

    // R8
    no_ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pump_dn && !ref_rise) |=> pump_dn);
endmodule

bind pfd_top pfd_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_rise    (ref_rise),
    .fbk_rise    (fbk_rise),
    .pump_up     (pump_up),
    .pump_dn     (pump_dn),
    .status_idle (status_idle),
    .locked      (locked)
);

// File: tb/pfd_top_tb.sv
`timescale 1ns/1ps
module pfd_top_tb;
    localparam int LP = 4;
    localparam int MC = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fbk_in = 1'b0;
    logic drive_en, drive_lvl, pump_up, pump_dn, status_idle, locked;

    int checks = 0;
    int errors = 0;
    int up_cnt = 0;
    int dn_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pfd_top #(.SYNC_STAGES(2), .LOCK_PERIODS(LP), .MAX_CORR(MC)) u_dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fbk_in(fbk_in),
        .drive_en(drive_en), .drive_lvl(drive_lvl), .pump_up(pump_up),
        .pump_dn(pump_dn), .status_idle(status_idle), .locked(locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample outputs at the falling edge, then drive the next inputs.
    task automatic tick(input logic r, input logic f);
        @(negedge clk);
        if (pump_up) up_cnt++;
        if (pump_dn) dn_cnt++;
        check(!(pump_up && pump_dn), "R4 pumps exclusive", int'(pump_up && pump_dn), 0);
        check(pump_up == (drive_en && drive_lvl) && pump_dn == (drive_en && !drive_lvl),
              "R4 encoding", int'({pump_up, pump_dn}), int'({drive_en && drive_lvl, drive_en && !drive_lvl}));
        check(status_idle == !drive_en, "R5 status", int'(status_idle), int'(!drive_en));
        ref_in = r;
        fbk_in = f;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        rst = 1'b0;
        up_cnt = 0;
        dn_cnt = 0;
    endtask

    // Reference rises at rs, feedback at fs; both stay high for hr cycles.
    task automatic do_pair(input int d, input int hr);
        int rs, fs;
        rs = 2 + ((d < 0) ? -d : 0);
        fs = 2 + ((d > 0) ? d : 0);
        up_cnt = 0;
        dn_cnt = 0;
        for (int i = 0; i < 30; i++)
            tick(i >= rs && i < rs + hr, i >= fs && i < fs + hr);
        if (d == 0) begin
            check(up_cnt == 0 && dn_cnt == 0, "R7 simultaneous edges", up_cnt + dn_cnt, 0);
        end else begin
            check(up_cnt == ((d > 0) ? d : 0), "R2 pump-up length (R6)", up_cnt, (d > 0) ? d : 0);
            check(dn_cnt == ((d < 0) ? -d : 0), "R3 pump-down length (R6)", dn_cnt, (d < 0) ? -d : 0);
        end
        check(status_idle == 1'b1, "R5 idle after pair", int'(status_idle), 1);
    endtask

    task automatic clean_periods(input int n);
        for (int p = 0; p < n; p++)
            for (int i = 0; i < 8; i++)
                tick(i < 4, i < 4);
    endtask

    task automatic run_freq(input int pr, input int pf, input int roff, input int foff, input int len);
        up_cnt = 0;
        dn_cnt = 0;
        for (int i = 0; i < len; i++)
            tick(((i + pr - roff) % pr) < pr / 2, ((i + pf - foff) % pf) < pf / 2);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check(drive_en == 0 && pump_up == 0 && pump_dn == 0, "R1 reset outputs", int'(drive_en), 0);
        check(status_idle == 1 && locked == 0, "R1 reset status/lock", int'({status_idle, locked}), 2);

        // R2 R3 R6 R7: sweep edge spacing and high time
        for (int d = -7; d <= 7; d++)
            for (int hr = 1; hr <= 4; hr++)
                do_pair(d, hr);

        // R6: ref falls while pump-up is active; state must not change
        up_cnt = 0;
        for (int i = 0; i < 20; i++) tick(i >= 1 && i < 3, i >= 9);
        check(up_cnt == 8, "R6 falling edge ignored", up_cnt, 8);
        tick(1'b0, 1'b0);

        // R8: no reference edges
        do_reset();
        for (int i = 0; i < 48; i++) tick(1'b0, (i % 8) < 3);
        check(dn_cnt == 45, "R8 stays pump-down", dn_cnt, 45);
        check(up_cnt == 0, "R8 no pump-up", up_cnt, 0);

        // R1: reset in the middle of a correction
        rst = 1'b1;
        tick(1'b0, 1'b0);
        check(status_idle == 1 && drive_en == 0, "R1 reset mid-correction", int'(status_idle), 1);
        rst = 1'b0;
        tick(1'b0, 1'b0);

        // R9: slower feedback
        do_reset();
        run_freq(10, 20, 0, 3, 200);
        check(dn_cnt == 0, "R9 slow feedback no pump-down", dn_cnt, 0);
        check(up_cnt * 2 > 200, "R9 slow feedback mostly up", up_cnt, 101);
        // R9: faster feedback
        do_reset();
        run_freq(20, 10, 3, 0, 200);
        check(up_cnt == 0, "R9 fast feedback no pump-up", up_cnt, 0);
        check(dn_cnt * 2 > 200, "R9 fast feedback mostly down", dn_cnt, 101);

        // R10: lock acquisition
        do_reset();
        clean_periods(LP - 1);
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
        check(locked == 0, "R10 not yet locked", int'(locked), 0);
        clean_periods(1);
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
        check(locked == 1, "R10 locked", int'(locked), 1);

        // R11: correction at and beyond the threshold
        do_pair(MC, 3);
        check(locked == 1, "R11 correction of MAX_CORR keeps lock", int'(locked), 1);
        do_pair(-MC, 3);
        check(locked == 1, "R11 pump-down of MAX_CORR keeps lock", int'(locked), 1);
        do_pair(MC + 1, 3);
        check(locked == 0, "R11 long correction clears lock", int'(locked), 0);
        clean_periods(LP + 1);
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
        check(locked == 1, "R10 relock", int'(locked), 1);
        do_pair(-(MC + 1), 3);
        check(locked == 0, "R11 long pump-down clears lock", int'(locked), 0);

        done = 1'b1;
        finish_run();
    end
endmodule